// File: doc/BRIEF.md
# Discovery Data Object Responder

This block serves one protocol of a mailbox-based data object exchange: the discovery request. After a start strobe, it reads the request's length DW and index DW from a request buffer through a synchronous read port. It then writes a three-DW response into a response buffer through a write port. The response is two header DWs and one payload DW. The payload names the protocol that sits at the requested index and gives the index that software should ask for next. The table of supported protocols arrives as a constant input. It holds a vendor ID and an object type per entry and leaves out discovery itself.

Index zero always stands for discovery. Index i from 1 up reports table entry i-1. Any index past the end of the table reports an all-ones marker. A request whose length field is too short for a full discovery request is dropped. In that case the block ends with a done pulse, no success pulse and no writes. A host mailbox controller starts the block once a request has been received, and it waits for done.

Top module: `disc_responder`

## Requirements
- R1: After reset, `done_o`, `success_o`, `rd_en_o` and `wr_en_o` are all low.
- R2: A start strobe reads request address 1 (the length DW) and then address 2 (the index DW), one read per cycle. The buffer returns data one cycle after each read.
- R3: If the 18-bit length in bits [17:0] of request DW1 is 1 or 2, the request is dropped. `done_o` pulses with `success_o` low, and no response DW is written.
- R4: A length field of 0 stands for 2^18 DWs and is accepted. So is any length of 3 or more.
- R5: Response DW0 (address 0) is the first header: vendor ID 0x0001 in bits [15:0], object type 0x00 in bits [23:16], and zero above. The value is 0x00000001.
- R6: Response DW1 (address 1) is the second header: length 3 in bits [17:0], and zero above.
- R7: Index 0 reports vendor ID 0x0001 and type 0x00 in the payload (address 2). The payload carries the vendor ID in [15:0], the type in [23:16] and the next index in [31:24].
- R8: An index i with 1 <= i <= NUM_ENTRIES reports the vendor ID and type of table entry i-1.
- R9: An index above NUM_ENTRIES reports vendor ID 0xFFFF and type 0xFF, with next index 0.
- R10: The next index is index+1, except for the last valid index (index = NUM_ENTRIES), which gives 0.
- R11: The three response DWs are written in consecutive cycles at addresses 0, 1 and 2. `done_o` and `success_o` rise together in the cycle after the last write, and each is a one-cycle pulse.
- R12: A start strobe that arrives while a request is in progress is ignored. The request still produces exactly three writes and one done pulse.
- R13: Only bits [7:0] of request DW2 form the index. The upper bits do not change the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin processing the request in the buffer |
| tbl_vid_i | input | NUM_ENTRIES*16 | Vendor ID of each table entry (packed array) |
| tbl_type_i | input | NUM_ENTRIES*8 | Object type of each table entry (packed array) |
| rd_en_o | output | 1 | Request buffer read strobe |
| rd_addr_o | output | AW | Request buffer DW address |
| rd_data_i | input | 32 | Request buffer data, valid one cycle after the read |
| wr_en_o | output | 1 | Response buffer write strobe |
| wr_addr_o | output | AW | Response buffer DW address |
| wr_data_o | output | 32 | Response DW |
| done_o | output | 1 | One-cycle end-of-request pulse |
| success_o | output | 1 | One-cycle pulse, together with done, when a response was written |

## Verification
A corrupted controller state shows up within a few cycles of the start strobe. It appears as a missing or repeated read of address 1 or 2, as writes out of address order, or as a done pulse that does not arrive exactly one cycle after the write to address 2. A wrong latched length decision shows directly as writes after a dropped request, or as a done pulse without success after a valid one. A wrong latched index or lookup result appears only in the payload DW. The bench therefore compares every payload field for indices zero, mid-table, last and past the end.

// File: rtl/disc_pkg.sv
package disc_pkg;

    localparam int          DW_W       = 32;
    localparam int          IDX_W      = 8;
    localparam int          LEN_W      = 18;
    localparam int          REQ_DW     = 3;
    localparam int          RSP_DW     = 3;
    localparam logic [15:0] SIG_VID    = 16'h0001;
    localparam logic [7:0]  DISC_TYPE  = 8'h00;
    localparam logic [15:0] NONE_VID   = 16'hFFFF;
    localparam logic [7:0]  NONE_TYPE  = 8'hFF;

    typedef struct packed {
        logic [15:0] vid;
        logic [7:0]  otype;
    } proto_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASK_LEN,
        ST_ASK_IDX,
        ST_JUDGE,
        ST_W0,
        ST_W1,
        ST_W2
    } st_t;

    function automatic logic [DW_W-1:0] mk_hdr1(input proto_t p);
        return {8'h00, p.otype, p.vid};
    endfunction

    function automatic logic [DW_W-1:0] mk_hdr2(input logic [LEN_W-1:0] len);
        return {{(DW_W-LEN_W){1'b0}}, len};
    endfunction

    function automatic logic [DW_W-1:0] mk_payload(input proto_t p,
                                                   input logic [IDX_W-1:0] nxt);
        return {nxt, p.otype, p.vid};
    endfunction

    // zero encodes the maximum object size, so it never counts as short
    function automatic logic len_short(input logic [LEN_W-1:0] len);
        return (len != '0) && (len < LEN_W'(REQ_DW));
    endfunction

endpackage

// File: rtl/disc_lookup.sv
module disc_lookup
    import disc_pkg::*;
#(
    parameter int NUM_ENTRIES = 3
) (
    input  logic [IDX_W-1:0]                   idx_i,
    input  logic [NUM_ENTRIES-1:0][15:0]       tbl_vid_i,
    input  logic [NUM_ENTRIES-1:0][7:0]        tbl_type_i,
    output proto_t                             ent_o,
    output logic [IDX_W-1:0]                   nxt_o
);
    localparam int COUNT = NUM_ENTRIES + 1;

    logic [NUM_ENTRIES-1:0] hit;
    proto_t                 tbl_sel;
    logic [IDX_W:0]         idx_p1;
    logic                   in_range;
    logic                   is_last;

    genvar k;
    generate
        for (k = 0; k < NUM_ENTRIES; k++) begin : g_hit
            assign hit[k] = (idx_i == IDX_W'(k + 1));
        end
    endgenerate

    always_comb begin
        tbl_sel = '0;
        for (int j = 0; j < NUM_ENTRIES; j++) begin
            if (hit[j]) begin
                tbl_sel.vid   = tbl_sel.vid   | tbl_vid_i[j];
                tbl_sel.otype = tbl_sel.otype | tbl_type_i[j];
            end
        end
    end

    assign idx_p1   = {1'b0, idx_i} + (IDX_W+1)'(1);
    assign in_range = ({1'b0, idx_i} < (IDX_W+1)'(COUNT));
    assign is_last  = (idx_p1 == (IDX_W+1)'(COUNT));

    always_comb begin
        if (idx_i == '0) begin
            ent_o.vid   = SIG_VID;
            ent_o.otype = DISC_TYPE;
        end else if (in_range) begin
            ent_o = tbl_sel;
        end else begin
            ent_o.vid   = NONE_VID;
            ent_o.otype = NONE_TYPE;
        end
    end

    assign nxt_o = (!in_range || is_last) ? '0 : idx_p1[IDX_W-1:0];

endmodule

// File: rtl/disc_fsm.sv
module disc_fsm
    import disc_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [DW_W-1:0]  rd_data_i,
    output st_t              state_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             rd_en_o,
    output logic [AW-1:0]    rd_addr_o,
    output logic             done_o,
    output logic             success_o
);
    st_t              state_q, state_d;
    logic             short_q;
    logic [IDX_W-1:0] idx_q;
    logic             done_q, success_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_ASK_LEN;
            ST_ASK_LEN: state_d = ST_ASK_IDX;
            ST_ASK_IDX: state_d = ST_JUDGE;
            ST_JUDGE:   state_d = short_q ? ST_IDLE : ST_W0;
            ST_W0:      state_d = ST_W1;
            ST_W1:      state_d = ST_W2;
            ST_W2:      state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            short_q   <= 1'b0;
            idx_q     <= '0;
            done_q    <= 1'b0;
            success_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            done_q    <= 1'b0;
            success_q <= 1'b0;
            if (state_q == ST_ASK_IDX) begin
                short_q <= len_short(rd_data_i[LEN_W-1:0]);
            end
            if (state_q == ST_JUDGE) begin
                idx_q <= rd_data_i[IDX_W-1:0];
                if (short_q) begin
                    done_q <= 1'b1;
                end
            end
            if (state_q == ST_W2) begin
                done_q    <= 1'b1;
                success_q <= 1'b1;
            end
        end
    end

    assign rd_en_o   = (state_q == ST_ASK_LEN) || (state_q == ST_ASK_IDX);
    assign rd_addr_o = (state_q == ST_ASK_IDX) ? AW'(2) : AW'(1);
    assign state_o   = state_q;
    assign idx_o     = idx_q;
    assign done_o    = done_q;
    assign success_o = success_q;

endmodule

// File: rtl/disc_rsp_pack.sv
module disc_rsp_pack
    import disc_pkg::*;
#(
    parameter int AW = 4
) (
    input  st_t              state_i,
    input  proto_t           ent_i,
    input  logic [IDX_W-1:0] nxt_i,
    output logic             wr_en_o,
    output logic [AW-1:0]    wr_addr_o,
    output logic [DW_W-1:0]  wr_data_o
);
    proto_t self_p;

    always_comb begin
        self_p.vid   = SIG_VID;
        self_p.otype = DISC_TYPE;
        wr_en_o   = 1'b0;
        wr_addr_o = '0;
        wr_data_o = '0;
        unique case (state_i)
            ST_W0: begin
                wr_en_o   = 1'b1;
                wr_addr_o = AW'(0);
                wr_data_o = mk_hdr1(self_p);
            end
            ST_W1: begin
                wr_en_o   = 1'b1;
                wr_addr_o = AW'(1);
                wr_data_o = mk_hdr2(LEN_W'(RSP_DW));
            end
            ST_W2: begin
                wr_en_o   = 1'b1;
                wr_addr_o = AW'(2);
                wr_data_o = mk_payload(ent_i, nxt_i);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/disc_responder.sv
module disc_responder
    import disc_pkg::*;
#(
    parameter int NUM_ENTRIES = 3,
    parameter int AW          = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             start_i,
    input  logic [NUM_ENTRIES-1:0][15:0]     tbl_vid_i,
    input  logic [NUM_ENTRIES-1:0][7:0]      tbl_type_i,
    output logic                             rd_en_o,
    output logic [AW-1:0]                    rd_addr_o,
    input  logic [31:0]                      rd_data_i,
    output logic                             wr_en_o,
    output logic [AW-1:0]                    wr_addr_o,
    output logic [31:0]                      wr_data_o,
    output logic                             done_o,
    output logic                             success_o
);
    st_t              state;
    logic [IDX_W-1:0] idx;
    proto_t           ent;
    logic [IDX_W-1:0] nxt;

    disc_fsm #(.AW(AW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .rd_data_i (rd_data_i),
        .state_o   (state),
        .idx_o     (idx),
        .rd_en_o   (rd_en_o),
        .rd_addr_o (rd_addr_o),
        .done_o    (done_o),
        .success_o (success_o)
    );

    disc_lookup #(.NUM_ENTRIES(NUM_ENTRIES)) u_lookup (
        .idx_i      (idx),
        .tbl_vid_i  (tbl_vid_i),
        .tbl_type_i (tbl_type_i),
        .ent_o      (ent),
        .nxt_o      (nxt)
    );

    disc_rsp_pack #(.AW(AW)) u_pack (
        .state_i   (state),
        .ent_i     (ent),
        .nxt_i     (nxt),
        .wr_en_o   (wr_en_o),
        .wr_addr_o (wr_addr_o),
        .wr_data_o (wr_data_o)
    );

endmodule

// File: rtl/disc_responder_chk.sv
module disc_responder_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_en_o,
    input logic [AW-1:0] rd_addr_o,
    input logic          wr_en_o,
    input logic [AW-1:0] wr_addr_o,
    input logic [31:0]   wr_data_o,
    input logic          done_o,
    input logic          success_o
);
    AST_RD_ORDER: assert property (@(posedge clk) disable iff (rst)
        (rd_en_o && rd_addr_o == AW'(1)) |=> (rd_en_o && rd_addr_o == AW'(2))); // R2
    AST_NO_WR_ON_DROP: assert property (@(posedge clk) disable iff (rst)
        (done_o && !success_o) |-> $past(!wr_en_o)); // R3
    AST_HDR1_VALUE: assert property (@(posedge clk) disable iff (rst)
        (wr_en_o && wr_addr_o == AW'(0)) |-> (wr_data_o == 32'h0000_0001)); // R5
    AST_HDR2_LEN: assert property (@(posedge clk) disable iff (rst)
        (wr_en_o && wr_addr_o == AW'(1)) |-> (wr_data_o == 32'd3)); // R6
    AST_WR_ORDER: assert property (@(posedge clk) disable iff (rst)
        (wr_en_o && wr_addr_o == AW'(0)) |=> (wr_en_o && wr_addr_o == AW'(1))); // R11
    AST_SUCC_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        success_o |-> (done_o && $past(wr_en_o && wr_addr_o == AW'(2)))); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R11
endmodule

bind disc_responder disc_responder_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_en_o   (rd_en_o),
    .rd_addr_o (rd_addr_o),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .done_o    (done_o),
    .success_o (success_o)
);

// File: tb/disc_responder_bench.sv
module disc_responder_bench;
    localparam int NE = 3;
    localparam int AW = 4;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 start = 1'b0;
    logic [NE-1:0][15:0]  tbl_vid  = {16'hABCD, 16'h1E98, 16'h1E98};
    logic [NE-1:0][7:0]   tbl_type = {8'h7F,    8'h03,    8'h02};
    logic                 rd_en, wr_en, done, success;
    logic [AW-1:0]        rd_addr, wr_addr;
    logic [31:0]          rd_data = '0;
    logic [31:0]          wr_data;

    logic [31:0] reqbuf [4];
    logic [31:0] rsp    [4];
    int wr_log [8];
    int rd_log [8];
    int wr_cnt, rd_cnt, done_cnt, cyc, last_wr_cyc, done_cyc;
    bit got_succ;
    int tests = 0, fails = 0;

    always #5 clk = ~clk;

    disc_responder #(.NUM_ENTRIES(NE), .AW(AW)) u_disc_responder (
        .clk (clk), .rst (rst), .start_i (start),
        .tbl_vid_i (tbl_vid), .tbl_type_i (tbl_type),
        .rd_en_o (rd_en), .rd_addr_o (rd_addr), .rd_data_i (rd_data),
        .wr_en_o (wr_en), .wr_addr_o (wr_addr), .wr_data_o (wr_data),
        .done_o (done), .success_o (success)
    );

    always_ff @(posedge clk) if (rd_en) rd_data <= reqbuf[rd_addr[1:0]];

    always @(negedge clk) begin
        cyc++;
        if (wr_en) begin
            rsp[wr_addr[1:0]] = wr_data;
            if (wr_cnt < 8) wr_log[wr_cnt] = int'(wr_addr);
            wr_cnt++;
            last_wr_cyc = cyc;
        end
        if (rd_en) begin
            if (rd_cnt < 8) rd_log[rd_cnt] = int'(rd_addr);
            rd_cnt++;
        end
        if (done) begin
            done_cnt++;
            got_succ = success;
            done_cyc = cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_req(input logic [31:0] len_dw, input logic [31:0] idx_dw, input bit twice);
        reqbuf[0] = 32'h0000_0001;
        reqbuf[1] = len_dw;
        reqbuf[2] = idx_dw;
        reqbuf[3] = 32'hDEAD_BEEF;
        for (int i = 0; i < 4; i++) rsp[i] = 32'hX;
        wr_cnt = 0; rd_cnt = 0; done_cnt = 0; got_succ = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (twice) begin
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        repeat (12) @(negedge clk);
    endtask

    task automatic check_good(input string req, input logic [31:0] exp_pl);
        chk(done_cnt == 1 && got_succ, req, 32'(done_cnt), 32'd1);
        chk(wr_cnt == 3, req, 32'(wr_cnt), 32'd3);
        chk(rsp[0] == 32'h0000_0001, "R5", rsp[0], 32'h0000_0001);
        chk(rsp[1] == 32'd3, "R6", rsp[1], 32'd3);
        chk(rsp[2] === exp_pl, req, rsp[2], exp_pl);
    endtask

    task automatic t_reset;
        chk(!done && !success && !rd_en && !wr_en, "R1",
            {28'd0, done, success, rd_en, wr_en}, 32'd0);
    endtask

    task automatic t_index0; // R7
        run_req(32'd3, 32'd0, 0);
        check_good("R7", 32'h0100_0001);
        chk(rd_cnt == 2 && rd_log[0] == 1 && rd_log[1] == 2, "R2",
            32'(rd_log[0] * 16 + rd_log[1]), 32'h12);
        chk(wr_log[0] == 0 && wr_log[1] == 1 && wr_log[2] == 2 && last_wr_cyc - 2 >= 0,
            "R11", 32'(wr_log[1]), 32'd1);
        chk(done_cyc == last_wr_cyc + 1, "R11", 32'(done_cyc - last_wr_cyc), 32'd1);
    endtask

    task automatic t_mid; // R8 R10
        run_req(32'd3, 32'd2, 0);
        check_good("R8", 32'h0303_1E98);
        run_req(32'd3, 32'd1, 0);
        check_good("R10", 32'h0202_1E98);
    endtask

    task automatic t_last; // R10
        run_req(32'd3, 32'd3, 0);
        check_good("R10", 32'h007F_ABCD);
    endtask

    task automatic t_oor; // R9
        run_req(32'd3, 32'd4, 0);
        check_good("R9", 32'h00FF_FFFF);
        run_req(32'd3, 32'd255, 0);
        check_good("R9", 32'h00FF_FFFF);
    endtask

    task automatic t_short; // R3
        run_req(32'd2, 32'd1, 0);
        chk(done_cnt == 1 && !got_succ, "R3", {31'd0, got_succ}, 32'd0);
        chk(wr_cnt == 0, "R3", 32'(wr_cnt), 32'd0);
        run_req(32'd1, 32'd0, 0);
        chk(done_cnt == 1 && !got_succ && wr_cnt == 0, "R3", 32'(wr_cnt), 32'd0);
    endtask

    task automatic t_len_zero; // R4
        run_req(32'hFFFC_0000, 32'd0, 0);
        check_good("R4", 32'h0100_0001);
        run_req(32'd40, 32'd2, 0);
        check_good("R4", 32'h0303_1E98);
    endtask

    task automatic t_upper; // R13
        run_req(32'd3, 32'hA5C3_0002, 0);
        check_good("R13", 32'h0303_1E98);
    endtask

    task automatic t_busy; // R12
        run_req(32'd3, 32'd1, 1);
        chk(done_cnt == 1 && wr_cnt == 3, "R12", 32'(wr_cnt), 32'd3);
        chk(rsp[2] == 32'h0202_1E98, "R12", rsp[2], 32'h0202_1E98);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_index0();
        t_mid();
        t_last();
        t_oor();
        t_short();
        t_len_zero();
        t_upper();
        t_busy();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule